// File: doc/BRIEF.md
# Master clock selector and prescaler

The block takes four free-running source clocks (a slow clock, a main oscillator clock and two PLL clocks), picks one of them, divides it by a power of two and then by a small integer. The result is two clocks: a processor clock after the prescaler, and a master clock after the second divider. Choosing the slow source puts everything downstream on the low-frequency clock (slow clock mode). A single 8-bit control word, written from the register clock domain, holds the source, the prescaler code, the divider code and an interrupt enable.

Each time the configuration is changed, the running clock is stopped cleanly and the new settings are applied while nothing toggles. The new source is then started, and a ready flag is raised once the new master clock has completed a fixed number of cycles. Software can watch this flag, or take an interrupt from it, to learn when a slow-down or speed-up has actually taken effect. Writing the value that is already held is illegal. Such a write is dropped and recorded in a sticky error flag.

Top module: `mclk_master`

## Requirements
- R1: Control bits [1:0] select the source: 0 slow, 1 main, 2 PLL A, 3 PLL B. The master clock period is the selected source period times the prescale ratio times the divide ratio.
- R2: Control bits [4:2] hold a prescaler code n. Codes 0 to 6 divide the selected source by 2^n to form `pck_o`. Code 7 is reserved and divides by 1.
- R3: Control bits [6:5] hold a divider code d. `mck_o` is `pck_o` divided by d+1. Every ratio, including 3, gives a 50 % duty cycle.
- R4: A legal write clears `ready_o` on the clock edge that takes it. `ready_o` rises again only after the new master clock has produced at least LOCK_CYC rising edges.
- R5: After reset, `ready_o`, `irq_o` and `err_o` are 0. The block then runs the slow source with both ratios at 1 and raises `ready_o` on its own.
- R6: A write equal to the held control word is ignored. It leaves `ready_o` and the running clocks unchanged and sets `err_o`. `err_o` then stays set until reset.
- R7: Control bit 7 is the interrupt enable. `irq_o` is set when `ready_o` rises while the enable is 1. Any write, legal or not, clears it, and it never rises while the enable is 0.
- R8: At most one source is gated onto the output at any time. No high or low phase of `mck_o` is shorter than half the shortest source period in use.
- R9: A write that arrives while a switch is still in progress is not lost. The last value written is the one that ends up running, and `ready_o` rises only for that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset, register clock domain |
| clk_slow | input | 1 | Slow source clock (select code 0) |
| clk_main | input | 1 | Main oscillator clock (select code 1) |
| clk_plla | input | 1 | PLL A clock (select code 2) |
| clk_pllb | input | 1 | PLL B clock (select code 3) |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Control word: [1:0] source, [4:2] prescale, [6:5] divide, [7] interrupt enable |
| mck_o | output | 1 | Master clock |
| pck_o | output | 1 | Processor clock (prescaler output) |
| ready_o | output | 1 | Requested clock established |
| irq_o | output | 1 | Ready interrupt |
| err_o | output | 1 | Sticky flag for repeated-value writes |

## Verification
The main function is tried with every source and with a spread of prescale and divide codes: 1/1, 4/3, 64/2, reserved/4 and 2/2. Each measured period separates the source decode from the prescaler shift and from the integer divider. The odd ratio of 3 is checked for its high time as well, because that is the one that could come out lopsided. Two writes close together, the second landing while the slow source is still locking, show whether a late write is deferred and applied or dropped. A repeated write with the interrupt pending separates "ignored" from "clears the interrupt".

// File: rtl/mclk_pkg.sv
package mclk_pkg;

    localparam int NSRC    = 4;
    localparam int SEL_W   = $clog2(NSRC);
    localparam int PRES_W  = 3;
    localparam int MDIV_W  = 2;
    localparam int PCNT_W  = 1 << PRES_W;
    localparam int PRES_MAX = 6;

    typedef enum logic [SEL_W-1:0] {
        SRC_SLOW = 2'd0,
        SRC_MAIN = 2'd1,
        SRC_PLLA = 2'd2,
        SRC_PLLB = 2'd3
    } src_e;

    typedef struct packed {
        logic              ie;
        logic [MDIV_W-1:0] mdiv;
        logic [PRES_W-1:0] pres;
        src_e              src;
    } mck_cfg_t;

    localparam int CFG_W = $bits(mck_cfg_t);

    localparam mck_cfg_t CFG_RST = '{ie: 1'b0, mdiv: '0, pres: '0, src: SRC_SLOW};

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_LOCK = 2'd2
    } sw_state_e;

    // Reserved prescaler codes fall back to a ratio of one.
    function automatic logic [PRES_W-1:0] pres_shift(input logic [PRES_W-1:0] code);
        return (int'(code) > PRES_MAX) ? '0 : code;
    endfunction

endpackage

// File: rtl/mclk_glitch_mux.sv
module mclk_glitch_mux
    import mclk_pkg::*;
#(
    parameter int N   = NSRC,
    parameter int DEF = 0
)
(
    input  logic                 rst,
    input  logic [N-1:0]         src_clk,
    input  logic                 req_vld,
    input  logic [$clog2(N)-1:0] req_sel,
    output logic [N-1:0]         gate_on,
    output logic                 out_clk
);
    localparam int SW = $clog2(N);

    logic [N-1:0] gated;

    for (genvar i = 0; i < N; i++) begin : g_src
        localparam logic [N-1:0] SELF = {{(N-1){1'b0}}, 1'b1} << i;
        localparam logic         RSTV = (i == DEF);

        logic rs1, rs2;
        logic en1, en2;
        logic gate_q;
        logic want;

        // Local copy of reset, retimed to this source.
        always_ff @(posedge src_clk[i]) begin
            rs1 <= rst;
            rs2 <= rs1;
        end

        // Enable only when requested and every other path is closed.
        assign want = req_vld && (req_sel == SW'(i)) && !(|(gate_on & ~SELF));

        always_ff @(posedge src_clk[i]) begin
            if (rs2) begin
                en1 <= RSTV;
                en2 <= RSTV;
            end else begin
                en1 <= want;
                en2 <= en1;
            end
        end

        // Gate changes while the source is low, so no partial pulse passes.
        always_ff @(negedge src_clk[i]) begin
            if (rs2) gate_q <= RSTV;
            else     gate_q <= en2;
        end

        assign gate_on[i] = gate_q;
        assign gated[i]   = src_clk[i] & gate_q;
    end

    assign out_clk = |gated;

endmodule

// File: rtl/mclk_divider.sv
module mclk_divider
    import mclk_pkg::*;
(
    input  logic              rst,
    input  logic              sel_clk,
    input  logic [PRES_W-1:0] pres,
    input  logic [MDIV_W-1:0] mdiv,
    output logic              pck,
    output logic              mck
);
    logic              ps1, ps2;
    logic [PCNT_W-1:0] pcnt;
    logic [PRES_W-1:0] shift;

    logic              ds1, ds2;
    logic [MDIV_W-1:0] dcnt, dnext;
    logic              ph_p, ph_n;

    // Power-of-two prescaler: each counter bit is a clean divided clock.
    always_ff @(posedge sel_clk) begin
        ps1 <= rst;
        ps2 <= ps1;
    end

    always_ff @(posedge sel_clk) begin
        if (ps2) pcnt <= '0;
        else     pcnt <= pcnt + 1'b1;
    end

    assign shift = pres_shift(pres);

    always_comb begin
        if (shift == '0) pck = sel_clk;
        else             pck = pcnt[shift - 1'b1];
    end

    // Integer divider by mdiv+1 on the processor clock.
    always_ff @(posedge pck) begin
        ds1 <= rst;
        ds2 <= ds1;
    end

    assign dnext = (dcnt >= mdiv) ? '0 : dcnt + 1'b1;

    always_ff @(posedge pck) begin
        if (ds2) begin
            dcnt <= '0;
            ph_p <= 1'b1;
        end else begin
            dcnt <= dnext;
            ph_p <= (dnext == '0);
        end
    end

    // Half-cycle stretch for the odd ratio.
    always_ff @(negedge pck) begin
        if (ds2) ph_n <= 1'b0;
        else     ph_n <= ph_p;
    end

    always_comb begin
        case (mdiv)
            2'd0:    mck = pck;
            2'd1:    mck = dcnt[0];
            2'd2:    mck = ph_p | ph_n;
            default: mck = dcnt[1];
        endcase
    end

    // R3: in divide-by-three, the posedge phase lasts one pck cycle only.
    assert_div3_phase_R3: assert property (@(posedge pck) disable iff (ds2)
        (mdiv == 2'd2 && ph_p) |=> !ph_p);

endmodule

// File: rtl/mclk_lock.sv
module mclk_lock #(
    parameter int LOCK_CYC = 4
)
(
    input  logic rst,
    input  logic mck,
    input  logic tag,
    output logic ack
);
    localparam int CW = $clog2(LOCK_CYC + 1);
    localparam logic [CW-1:0] CMAX = CW'(LOCK_CYC);

    logic          rs1, rs2;
    logic          t1, t2;
    logic          last;
    logic [CW-1:0] cnt;

    always_ff @(posedge mck) begin
        rs1 <= rst;
        rs2 <= rs1;
    end

    // A new tag restarts the count; ack equals the tag once enough edges ran.
    always_ff @(posedge mck) begin
        if (rs2) begin
            t1   <= 1'b0;
            t2   <= 1'b0;
            last <= 1'b0;
            cnt  <= '0;
            ack  <= 1'b1;
        end else begin
            t1 <= tag;
            t2 <= t1;
            if (t2 != last) begin
                last <= t2;
                cnt  <= '0;
                ack  <= ~t2;
            end else begin
                if (cnt != CMAX) cnt <= cnt + 1'b1;
                ack <= (cnt == CMAX) ? last : ~last;
            end
        end
    end

    // R4: acknowledgement flips to the running tag only after a full count.
    assert_ack_after_count_R4: assert property (@(posedge mck) disable iff (rs2)
        (!$stable(ack) && ack == last && $past(t2) == $past(last)) |-> $past(cnt) == CMAX);

endmodule

// File: rtl/mclk_master.sv
module mclk_master
    import mclk_pkg::*;
#(
    parameter int LOCK_CYC = 4
)
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_slow,
    input  logic             clk_main,
    input  logic             clk_plla,
    input  logic             clk_pllb,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic             mck_o,
    output logic             pck_o,
    output logic             ready_o,
    output logic             irq_o,
    output logic             err_o
);
    logic [NSRC-1:0] src_clks;
    logic [NSRC-1:0] gate_on;
    logic            sel_clk;
    logic            ack;

    mck_cfg_t  wr_cfg, cfg_q, cfg_nxt, act_q;
    sw_state_e state_q;
    logic      tag_q, pend_q, ready_q, irq_q, err_q;
    logic      ga1, ga2, ak1, ak2;
    logic      same_wr, legal_wr, req_vld;

    assign src_clks = {clk_pllb, clk_plla, clk_main, clk_slow};

    assign wr_cfg   = mck_cfg_t'(wr_data);
    assign same_wr  = wr_en && (wr_cfg == cfg_q);
    assign legal_wr = wr_en && !same_wr;
    assign cfg_nxt  = legal_wr ? wr_cfg : cfg_q;
    assign req_vld  = (state_q != ST_HALT);

    mclk_glitch_mux #(.N(NSRC), .DEF(0)) u_mux (
        .rst     (rst),
        .src_clk (src_clks),
        .req_vld (req_vld),
        .req_sel (act_q.src),
        .gate_on (gate_on),
        .out_clk (sel_clk)
    );

    mclk_divider u_div (
        .rst     (rst),
        .sel_clk (sel_clk),
        .pres    (act_q.pres),
        .mdiv    (act_q.mdiv),
        .pck     (pck_o),
        .mck     (mck_o)
    );

    mclk_lock #(.LOCK_CYC(LOCK_CYC)) u_lock (
        .rst (rst),
        .mck (mck_o),
        .tag (tag_q),
        .ack (ack)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= CFG_RST;
            act_q   <= CFG_RST;
            state_q <= ST_LOCK;
            tag_q   <= 1'b0;
            pend_q  <= 1'b0;
            ready_q <= 1'b0;
            irq_q   <= 1'b0;
            err_q   <= 1'b0;
            ga1     <= 1'b0;
            ga2     <= 1'b0;
            ak1     <= 1'b1;
            ak2     <= 1'b1;
        end else begin
            ga1 <= |gate_on;
            ga2 <= ga1;
            ak1 <= ack;
            ak2 <= ak1;

            case (state_q)
                ST_RUN: begin
                    if (legal_wr) state_q <= ST_HALT;
                end
                ST_HALT: begin
                    // Settings change only while every source path is closed.
                    if (!ga2) begin
                        act_q   <= cfg_nxt;
                        tag_q   <= ~tag_q;
                        pend_q  <= 1'b0;
                        state_q <= ST_LOCK;
                    end
                end
                default: begin
                    if (legal_wr) pend_q <= 1'b1;
                    if (ak2 == tag_q && ga2) begin
                        if (pend_q || legal_wr) begin
                            state_q <= ST_HALT;
                        end else begin
                            state_q <= ST_RUN;
                            ready_q <= 1'b1;
                            irq_q   <= cfg_q.ie;
                        end
                    end
                end
            endcase

            if (legal_wr) begin
                cfg_q   <= wr_cfg;
                ready_q <= 1'b0;
            end
            if (same_wr) err_q <= 1'b1;
            if (wr_en)   irq_q <= 1'b0;
        end
    end

    assign ready_o = ready_q;
    assign irq_o   = irq_q;
    assign err_o   = err_q;

    // R8: never two sources gated at once.
    assert_single_gate_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gate_on));

    // R8: new settings reach the datapath only after the gates were seen closed.
    assert_apply_when_closed_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_q) |-> !$past(ga2));

    // R4: a legal write drops ready on the next edge.
    assert_write_drops_ready_R4: assert property (@(posedge clk) disable iff (rst)
        legal_wr |=> !ready_q);

    // R6: a repeated value keeps ready and flags the error.
    assert_repeat_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (same_wr && ready_q) |=> (ready_q && err_q));

    // R7: the interrupt only stands with ready and its enable.
    assert_irq_needs_ready_R7: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (ready_q && cfg_q.ie));

endmodule

// File: tb/test_mclk_master.sv
`timescale 1ns/1ps
module test_mclk_master;

    localparam int LOCK = 4;
    localparam realtime T_SLOW = 300.0;
    localparam realtime T_MAIN = 14.0;
    localparam realtime T_PLLA = 6.0;
    localparam realtime T_PLLB = 10.0;

    logic clk = 0, rst = 1;
    logic clk_slow = 0, clk_main = 0, clk_plla = 0, clk_pllb = 0;
    logic wr_en = 0;
    logic [7:0] wr_data = '0;
    logic mck_o, pck_o, ready_o, irq_o, err_o;

    always #10  clk = ~clk;
    always #150 clk_slow = ~clk_slow;
    always #7   clk_main = ~clk_main;
    always #3   clk_plla = ~clk_plla;
    always #5   clk_pllb = ~clk_pllb;

    mclk_master #(.LOCK_CYC(LOCK)) i_mclk_master (
        .clk(clk), .rst(rst),
        .clk_slow(clk_slow), .clk_main(clk_main), .clk_plla(clk_plla), .clk_pllb(clk_pllb),
        .wr_en(wr_en), .wr_data(wr_data),
        .mck_o(mck_o), .pck_o(pck_o), .ready_o(ready_o), .irq_o(irq_o), .err_o(err_o)
    );

    typedef struct {
        realtime mper;
        realtime pper;
        bit      ie;
        string   tag;
    } exp_t;

    exp_t exp_q[$];
    int   nchk = 0, nfail = 0;
    bit   busy = 0;
    int   mck_edges = 0;
    int   glitches = 0;
    bit   armed = 0;
    realtime last_edge = 0.0;

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: got %0.3f expected %0.3f", req, what, act, expv);
        end
    endtask

    function automatic realtime src_per(input int s);
        case (s)
            0: return T_SLOW;
            1: return T_MAIN;
            2: return T_PLLA;
            default: return T_PLLB;
        endcase
    endfunction

    function automatic exp_t make_exp(input int s, input int p, input int d,
                                      input bit ie, input string tag);
        exp_t e;
        int ratio;
        ratio  = (p > 6) ? 1 : (1 << p);
        e.pper = src_per(s) * ratio;
        e.mper = e.pper * (d + 1);
        e.ie   = ie;
        e.tag  = tag;
        return e;
    endfunction

    always @(posedge mck_o) mck_edges++;

    // R8: narrowest legal phase is half of the fastest source period.
    always @(mck_o) begin
        if (armed && ($realtime - last_edge) < 2.9) glitches++;
        last_edge = $realtime;
    end

    task automatic write_cfg(input int s, input int p, input int d, input bit ie);
        @(negedge clk);
        wr_en   = 1;
        wr_data = {ie, 2'(d), 3'(p), 2'(s)};
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0 || busy) @(negedge clk);
    endtask

    task automatic run_cfg(input int s, input int p, input int d, input bit ie, input string tag);
        write_cfg(s, p, d, ie);
        check(ready_o == 0, "R4", "ready after write", real'(ready_o), 0.0);
        exp_q.push_back(make_exp(s, p, d, ie, tag));
        wait_idle();
    endtask

    // Monitor: pops the expected clock and compares once ready is seen.
    initial begin
        forever begin
            exp_t e;
            int e0;
            realtime t0, hi, per, pper;
            while (exp_q.size() == 0) @(negedge clk);
            busy = 1;
            e  = exp_q.pop_front();
            e0 = mck_edges;
            while (!ready_o) @(negedge clk);
            check(mck_edges - e0 >= LOCK, "R4", "mck edges before ready",
                  real'(mck_edges - e0), real'(LOCK));
            check(irq_o == e.ie, "R7", "irq at ready", real'(irq_o), real'(e.ie));
            @(posedge mck_o);
            t0 = $realtime;
            @(negedge mck_o);
            hi = $realtime - t0;
            repeat (3) @(posedge mck_o);
            per = ($realtime - t0) / 3.0;
            check(per > e.mper - 0.01 && per < e.mper + 0.01, e.tag, "mck period", per, e.mper);
            check(hi > e.mper / 2.0 - 0.01 && hi < e.mper / 2.0 + 0.01, "R3", "mck high time",
                  hi, e.mper / 2.0);
            @(posedge pck_o);
            t0 = $realtime;
            repeat (2) @(posedge pck_o);
            pper = ($realtime - t0) / 2.0;
            check(pper > e.pper - 0.01 && pper < e.pper + 0.01, "R2", "pck period", pper, e.pper);
            armed = 1;
            busy  = 0;
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        #(100000 * 20);
        nchk++;
        nfail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        realtime t0, per;
        repeat (150) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R5 reset state
        check(ready_o == 0, "R5", "ready after reset", real'(ready_o), 0.0);
        check(irq_o == 0,   "R5", "irq after reset",   real'(irq_o),   0.0);
        check(err_o == 0,   "R5", "err after reset",   real'(err_o),   0.0);
        exp_q.push_back(make_exp(0, 0, 0, 0, "R5"));
        wait_idle();

        run_cfg(1, 0, 0, 1, "R1");     // main, 1, 1
        run_cfg(2, 2, 2, 1, "R3");     // PLL A, 4, 3
        run_cfg(3, 6, 1, 0, "R2");     // PLL B, 64, 2
        run_cfg(1, 7, 3, 1, "R2");     // main, reserved code, 4
        run_cfg(2, 0, 0, 1, "R1");     // PLL A, 1, 1

        // R6 / R7: repeated value
        check(err_o == 0, "R6", "err before repeat", real'(err_o), 0.0);
        check(irq_o == 1, "R7", "irq before repeat", real'(irq_o), 1.0);
        write_cfg(2, 0, 0, 1);
        check(err_o == 1,   "R6", "err after repeat",   real'(err_o),   1.0);
        check(ready_o == 1, "R6", "ready after repeat", real'(ready_o), 1.0);
        check(irq_o == 0,   "R7", "irq cleared by write", real'(irq_o), 0.0);
        @(posedge mck_o);
        t0 = $realtime;
        repeat (4) @(posedge mck_o);
        per = ($realtime - t0) / 4.0;
        check(per > T_PLLA - 0.01 && per < T_PLLA + 0.01, "R6", "mck after repeat", per, T_PLLA);

        // R9: second write lands while the slow source is still locking
        run_cfg(3, 1, 0, 1, "R1");
        write_cfg(0, 0, 0, 1);
        check(ready_o == 0, "R4", "ready after first write", real'(ready_o), 0.0);
        repeat (10) @(negedge clk);
        check(ready_o == 0, "R9", "ready while switching", real'(ready_o), 0.0);
        run_cfg(1, 1, 3, 1, "R9");
        check(err_o == 1, "R6", "err stays sticky", real'(err_o), 1.0);

        run_cfg(0, 1, 1, 0, "R1");     // slow, 2, 2, interrupt off

        check(glitches == 0, "R8", "narrow mck phases", real'(glitches), 0.0);
        finish_run();
    end

endmodule